// File: doc/BRIEF.md
# Rotate-Exchange Bit Permuter

This block computes a generalized rotate-with-exchange of a 32-bit operand. The source word is copied into both halves of a 64-bit working value. Five stages follow, each moving bits down by 16, 8, 4, 2 and then 1 places. In every stage each bit position chooses one of two shift amounts according to its own position index, so a single network can do a plain right rotate and also byte, halfword or bit reorderings such as byte reversal. A stripe flag inverts the amount selection in the first stage for alternating groups of four bits.

The three controls come from a 32-bit instruction word through a small decoder inside the block. That decoder also extracts a destination register index, and the write enable is dropped when that index is zero. The 32-bit result leaves the block sign-extended to 64 bits. The parameter `OUT_REG` chooses between a purely combinational path and one registered output stage with synchronous reset.

Top module: `bitperm_xchg`

## Requirements
- R1: When instr[10:7] equals instr[4:1] and instr[6] is 0, result[31:0] is src rotated right by instr[4:0].
- R2: The primary amount is instr[4:0] and the secondary amount is {instr[10:7],1'b0}. Stripe is instr[6] and the destination index is instr[25:21]. No other instruction bit affects any output.
- R3: Stage 1 acts on positions 0..46 of the duplicated word {src,src}. A position takes the bit 16 places above it when bit 4 of its selected amount is 1. The selected amount is the primary amount when position bit 3 is 1 and the secondary amount otherwise.
- R4: With stripe set, a stage-1 position whose index bit 2 is 0 tests the inverted selected amount. Stripe has no effect on stages 2 to 5.
- R5: Stages 2, 3 and 4 use distances 8, 4 and 2 over positions 0..38, 0..34 and 0..32. They test amount bits 3, 2 and 1, and choose the primary amount when position bit 2, 1 or 0 respectively is 1. Example: primary 8, secondary 0 gives (rotr(src,8) & 0xF0F0F0F0) | (src & 0x0F0F0F0F).
- R6: Stage 5 moves positions 0..31 down by 1 only when primary bit 0 is 1. Primary 1 with secondary 0 gives a right rotate by one.
- R7: result[63:32] always equals 32 copies of result[31].
- R8: wr_en is 1 exactly for a valid operation whose destination index is nonzero.
- R9: Primary 24, secondary 8 (instr[10:7]=4) and stripe 0 give src with its four bytes reversed.
- R10: With OUT_REG=1, out_valid, wr_en and result appear one clock after in_valid. While in_valid is 0, result holds its last value and out_valid is 0.
- R11: With OUT_REG=1, a clock edge with rst high clears out_valid, wr_en and result to 0.
- R12: With OUT_REG=0, outputs follow the inputs in the same cycle, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word carrying the controls and destination index |
| src | input | 32 | Operand to permute |
| out_valid | output | 1 | Result valid |
| wr_en | output | 1 | Write enable, low for destination index 0 |
| result | output | 64 | Permuted word, sign-extended |

## Verification
The combinational instance has no register, so its result, wr_en and out_valid are due in the same cycle as the stimulus. Inputs change on the falling edge and those outputs are sampled 1 ns later. The registered instance's results are due at the next rising edge, and they are sampled 1 ns after that edge while the inputs are still held. Every sweep vector is therefore checked once per instance in exactly one cycle. The hold and reset checks sample one rising edge after in_valid drops or rst rises.

// File: rtl/bitperm_xchg.sv
module bitperm_xchg #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] src,
  output logic        out_valid,
  output logic        wr_en,
  output logic [63:0] result
);
  localparam int W  = 32;
  localparam int LW = $clog2(W);
  localparam int XW = 2 * W;
  localparam int IW = $clog2(2 * W);
  localparam int AW = $clog2(LW);

  function automatic logic [2*W-1:0] stage_f(input logic [2*W-1:0] v, input int s,
                                             input logic [LW-1:0] ap, input logic [LW-1:0] ax,
                                             input logic st);
    int t, d, hi, pick;
    logic [LW-1:0] a;
    t = LW - 1 - s;
    d = 1 << t;
    hi = W + d - 2;
    stage_f = v;
    for (int i = 0; i < 2 * W - 1; i++) begin
      if (i <= hi) begin
        pick = (t == 0) ? 1 : ((i >> (t - 1)) & 1);
        a = (pick == 1) ? ap : ax;
        if (st && s == 0 && ((i >> (t - 2)) & 1) == 0) a = ~a;
        if (a[AW'(t)]) stage_f[IW'(i)] = v[IW'(i + d)];
      end
    end
  endfunction

  logic [LW-1:0] amt_p, amt_x;
  logic          stripe;
  logic [4:0]    dst;

  assign amt_p  = instr[4:0];
  assign amt_x  = {instr[10:7], 1'b0};
  assign stripe = instr[6];
  assign dst    = instr[25:21];

  logic [2*W-1:0] stg [0:LW];
  assign stg[0] = {src, src};

  for (genvar s = 0; s < LW; s++) begin : g_stage
    assign stg[s+1] = stage_f(stg[s], s, amt_p, amt_x, stripe);
  end

  logic unused_bits;
  assign unused_bits = ^{instr[31:26], instr[20:11], instr[5], stg[LW][2*W-1:W]};

  logic [XW-1:0] res_c;
  logic          wr_c;
  assign res_c = {{W{stg[LW][W-1]}}, stg[LW][W-1:0]};
  assign wr_c  = in_valid && (dst != 5'd0);

  if (OUT_REG) begin : g_reg
    logic          v_q, w_q;
    logic [XW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        w_q <= 1'b0;
        r_q <= '0;
      end else begin
        v_q <= in_valid;
        w_q <= wr_c;
        if (in_valid) r_q <= res_c;
      end
    end
    assign out_valid = v_q;
    assign wr_en     = w_q;
    assign result    = r_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign out_valid  = in_valid;
    assign wr_en      = wr_c;
    assign result     = res_c;
  end
endmodule

module bitperm_xchg_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [31:0] src,
  input logic        out_valid,
  input logic        wr_en,
  input logic [63:0] result
);
  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [4:0] n);
    logic [63:0] dd;
    dd = {v, v} >> n;
    return dd[31:0];
  endfunction

  if (OUT_REG) begin : g_reg
    assert_lat_R10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result)));
    assert_rot_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[10:7] == instr[4:1] && !instr[6]) |=>
        result[31:0] == rotr($past(src), $past(instr[4:0])));
    assert_wr_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[25:21] == 5'd0) |=> !wr_en);
    assert_rst_R11: assert property (@(posedge clk)
      rst |=> (!out_valid && !wr_en && result == 64'd0));
  end else begin : g_comb
    assert_same_R12: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);
    assert_rot_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[10:7] == instr[4:1] && !instr[6]) |->
        result[31:0] == rotr(src, instr[4:0]));
    assert_wr_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[25:21] == 5'd0) |-> !wr_en);
  end

  assert_wr_valid_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);
  assert_sext_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> result[63:32] == {32{result[31]}});
endmodule

bind bitperm_xchg bitperm_xchg_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
  .out_valid(out_valid), .wr_en(wr_en), .result(result)
);

// File: tb/test_bitperm_xchg.sv
`timescale 1ns/1ps
module test_bitperm_xchg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src = '0;
  logic        ov_r, wr_r, ov_c, wr_c;
  logic [63:0] res_r, res_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bitperm_xchg #(.OUT_REG(1'b1)) i_bitperm_xchg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(ov_r), .wr_en(wr_r), .result(res_r));

  bitperm_xchg #(.OUT_REG(1'b0)) i_bitperm_xchg_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(ov_c), .wr_en(wr_c), .result(res_c));

  function automatic logic [63:0] sext(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    logic [63:0] dd;
    dd = {v, v} >> n;
    return dd[31:0];
  endfunction

  function automatic logic [31:0] ref_perm(input logic [31:0] s, input logic [4:0] p,
                                           input logic [4:0] x, input logic st);
    logic [63:0] cur, nxt;
    logic [4:0]  a;
    cur = {s, s};
    nxt = cur;
    for (int i = 0; i <= 46; i++) begin
      a = i[3] ? p : x;
      if (st && !i[2]) a = ~a;
      if (a[4]) nxt[6'(i)] = cur[6'(i + 16)];
    end
    cur = nxt;
    for (int i = 0; i <= 38; i++) begin
      a = i[2] ? p : x;
      if (a[3]) nxt[6'(i)] = cur[6'(i + 8)];
    end
    cur = nxt;
    for (int i = 0; i <= 34; i++) begin
      a = i[1] ? p : x;
      if (a[2]) nxt[6'(i)] = cur[6'(i + 4)];
    end
    cur = nxt;
    for (int i = 0; i <= 32; i++) begin
      a = i[0] ? p : x;
      if (a[1]) nxt[6'(i)] = cur[6'(i + 2)];
    end
    cur = nxt;
    for (int i = 0; i <= 31; i++) begin
      if (p[0]) nxt[6'(i)] = cur[6'(i + 1)];
    end
    return nxt[31:0];
  endfunction

  function automatic logic [31:0] mk_instr(input logic [4:0] p, input logic [3:0] x4,
                                           input logic st, input logic [4:0] dst,
                                           input logic [16:0] g);
    return {g[5:0], dst, g[15:6], x4, st, g[16], p};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] last_exp;

  task automatic run_vec(input string tag, input logic [31:0] ins, input logic [31:0] s,
                         input logic [31:0] exp32);
    logic [63:0] e;
    logic        ew;
    e  = sext(exp32);
    ew = (ins[25:21] != 5'd0);
    @(negedge clk);
    in_valid = 1'b1;
    instr    = ins;
    src      = s;
    #1;
    chk({tag, " R12 comb result"}, res_c, e);
    chk("R12 comb out_valid", {63'd0, ov_c}, 64'd1);
    chk("R8 comb wr_en", {63'd0, wr_c}, {63'd0, ew});
    @(posedge clk);
    #1;
    chk({tag, " reg result"}, res_r, e);
    chk("R7 sign extension", {32'd0, res_r[63:32]}, {32'd0, {32{exp32[31]}}});
    chk("R10 out_valid after one clock", {63'd0, ov_r}, 64'd1);
    chk("R8 reg wr_en", {63'd0, wr_r}, {63'd0, ew});
    last_exp = e;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [31:0] ins;
    int idx;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset out_valid", {63'd0, ov_r}, 64'd0);
    chk("R11 reset wr_en", {63'd0, wr_r}, 64'd0);
    chk("R11 reset result", res_r, 64'd0);
    chk("R12 comb idle out_valid", {63'd0, ov_c}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 plain rotate, computed arithmetically
    for (int n = 0; n < 32; n++) begin
      s = 32'hC3A5_1F60 ^ (32'h0101_0101 * n);
      ins = mk_instr(5'(n), 4'(n >> 1), 1'b0, 5'd3, 17'h0);
      run_vec("R1 rotate", ins, s, rotr(s, n));
    end

    // R9 byte reversal
    s = 32'h8899_AABB;
    run_vec("R9 byte reverse", mk_instr(5'd24, 4'd4, 1'b0, 5'd7, 17'h0), s,
            {s[7:0], s[15:8], s[23:16], s[31:24]});
    s = 32'h1234_5678;
    run_vec("R9 byte reverse", mk_instr(5'd24, 4'd4, 1'b0, 5'd7, 17'h0), s,
            {s[7:0], s[15:8], s[23:16], s[31:24]});

    // R6 stage 5 alone
    s = 32'h0000_0001;
    run_vec("R6 stage5", mk_instr(5'd1, 4'd0, 1'b0, 5'd1, 17'h0), s, rotr(s, 1));
    // R5 stage 2 alone
    s = 32'hDEAD_BEEF;
    run_vec("R5 stage2", mk_instr(5'd8, 4'd0, 1'b0, 5'd1, 17'h0), s,
            (rotr(s, 8) & 32'hF0F0_F0F0) | (s & 32'h0F0F_0F0F));

    // R2 unrelated instruction bits ignored
    s = 32'h7654_3210;
    run_vec("R2 garbage bits", mk_instr(5'd13, 4'd9, 1'b1, 5'd9, 17'h1FFFF), s,
            ref_perm(s, 5'd13, 5'd18, 1'b1));
    run_vec("R2 garbage bits", mk_instr(5'd13, 4'd9, 1'b1, 5'd9, 17'h0A5A5), s,
            ref_perm(s, 5'd13, 5'd18, 1'b1));

    // R8 destination zero suppresses write
    run_vec("R8 dest zero", mk_instr(5'd5, 4'd2, 1'b0, 5'd0, 17'h0), s, rotr(s, 5));

    // R10 hold while idle
    @(negedge clk);
    in_valid = 1'b0;
    src = 32'hFFFF_0000;
    instr = mk_instr(5'd3, 4'd1, 1'b0, 5'd4, 17'h0);
    @(posedge clk);
    #1;
    chk("R10 idle out_valid", {63'd0, ov_r}, 64'd0);
    chk("R10 idle wr_en", {63'd0, wr_r}, 64'd0);
    chk("R10 result held", res_r, last_exp);

    // R3/R4 sweep against the bit-serial model
    idx = 0;
    for (int p = 0; p < 32; p++) begin
      for (int x = 0; x < 16; x++) begin
        for (int st = 0; st < 2; st++) begin
          for (int k = 0; k < 3; k++) begin
            s = (k == 0) ? 32'h1234_5678 : (k == 1) ? 32'h8000_0001 : 32'h9E37_79B9 * (idx + 1);
            ins = mk_instr(5'(p), 4'(x), st[0], 5'(idx), 17'(idx * 7));
            run_vec((st != 0) ? "R4 stripe sweep" : "R3 sweep", ins, s,
                    ref_perm(s, 5'(p), {4'(x), 1'b0}, st[0]));
            idx++;
          end
        end
      end
    end

    // R11 reset in mid-run
    @(negedge clk);
    in_valid = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 mid reset out_valid", {63'd0, ov_r}, 64'd0);
    chk("R11 mid reset wr_en", {63'd0, wr_r}, 64'd0);
    chk("R11 mid reset result", res_r, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule